// File: doc/BRIEF.md
# Mixed-Mode Fixed-Point Multiplier

This block multiplies two fixed-point words. A format control on each operand says whether that word is twos complement or unsigned, so the block covers signed by signed, unsigned by unsigned and both mixed pairings. A per-operand magnitude control can replace a twos-complement operand with its absolute value before the multiply. A product-shift control moves the product left by one bit. This aligns the binary point when both operands are fractions. The shift raises an overflow flag when it pushes a significant bit out of the product.

The block is a two-stage pipeline. The first clock edge captures the conditioned operands and the controls, and the multiplier runs from those registers. The second edge writes the double-width product and its overflow flag into the output register. A new operation can start on every cycle.

The output register holds the full double-width product. A select line picks which half drives the single-width data port, and it acts without a clock edge, so both halves can be read within one cycle. An output enable gates the port. When the enable is low the port is modelled as zero with a low valid flag, in place of high impedance. An active-low hold input freezes the output register.

Top module: `mixed_fxp_mul`

## Requirements
- R1: With both format controls low (unsigned), the output register holds a*b mod 2^(2W), where W is the operand width.
- R2: With both format controls high (twos complement), the output register holds the signed product as a 2W-bit twos-complement word.
- R3: With exactly one format control high, that operand is read as twos complement and the other as unsigned, and the 2W-bit twos-complement product is stored.
- R4: A magnitude control high on a twos-complement operand replaces that operand with its absolute value. The most negative code gives 2^(W-1). On an operand marked unsigned the magnitude control has no effect.
- R5: Operands and controls present at clock edge k appear in the output register after edge k+1. Operations issued on consecutive cycles come out on consecutive cycles.
- R6: With the enable high, half-select low drives product bits W-1..0 onto the data port and half-select high drives bits 2W-1..W, with no clock edge needed.
- R7: With the enable low, the data port reads all zeros and the valid output is low. With the enable high, the valid output is high.
- R8: With the shift control high, the stored product is the product shifted left by one, with a zero LSB, truncated to 2W bits.
- R9: Overflow is set only when the shift control is high. If either operand is twos complement, it is set when bits 2W-1 and 2W-2 of the unshifted product differ. If both are unsigned, it is set when bit 2W-1 of the unshifted product is one. The flag is registered with its product.
- R10: While hold_n is low, the output register and the overflow flag keep their values. The first stage still captures new operands.
- R11: Synchronous active-high reset clears the output register and the overflow flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| a_signed | input | 1 | Operand A is twos complement |
| b_signed | input | 1 | Operand B is twos complement |
| a_abs | input | 1 | Take magnitude of operand A |
| b_abs | input | 1 | Take magnitude of operand B |
| shift_left | input | 1 | Shift product left by one |
| hold_n | input | 1 | Active-low freeze of output register |
| hi_sel | input | 1 | Select upper half of product for the port |
| out_en | input | 1 | Output enable |
| dout | output | WIDTH | Selected product half |
| dout_valid | output | 1 | Port is driven (enable high) |
| ovf | output | 1 | Registered overflow flag |

## Verification
The assertions assume that reset is high from time zero until the first clock edge. They also assume that every control, including hold_n, is stable at each rising edge, so that the first stage's shift flag and the output register can be related one cycle apart. The stimulus changes every input only on falling edges. It releases reset only after several rising edges, and it reads the selected halves at the falling edge, when the output register has settled. The operand sweep runs on a narrow configuration of the design, so every operand pair meets every format, magnitude and shift setting.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

    // Control bits that ride along with the stage-one operand registers.
    typedef struct packed {
        logic shift;
        logic any_signed;
    } mfm_ctl_t;

    // Kind of an operand after its format control is applied.
    typedef enum logic [1:0] {
        OPK_UNSIGNED  = 2'd0,
        OPK_SIGNED    = 2'd1,
        OPK_MAGNITUDE = 2'd2
    } mfm_opkind_t;

    function automatic mfm_opkind_t opkind(input logic is_signed, input logic take_abs);
        if (!is_signed)    return OPK_UNSIGNED;
        else if (take_abs) return OPK_MAGNITUDE;
        else               return OPK_SIGNED;
    endfunction

endpackage

// File: rtl/mfm_operand.sv
module mfm_operand
    import mfm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]     raw,
    input  logic             is_signed,
    input  logic             take_abs,
    output logic signed [W:0] ext
);
    logic signed [W:0] widened;

    always_comb begin
        unique case (opkind(is_signed, take_abs))
            OPK_SIGNED:    widened = {raw[W-1], raw};
            OPK_MAGNITUDE: widened = {raw[W-1], raw};
            default:       widened = {1'b0, raw};
        endcase
        if (opkind(is_signed, take_abs) == OPK_MAGNITUDE && raw[W-1])
            ext = -widened;
        else
            ext = widened;
    end

endmodule

// File: rtl/mfm_stage1.sv
module mfm_stage1
    import mfm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic signed [W:0] a_ext,
    input  logic signed [W:0] b_ext,
    input  mfm_ctl_t          ctl_in,
    output logic [2*W-1:0]    prod,
    output mfm_ctl_t          ctl_out
);
    localparam int PW = 2 * W;

    logic signed [W:0] a_q, b_q;
    logic signed [PW-1:0] a_wide, b_wide, mult;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            b_q     <= '0;
            ctl_out <= '0;
        end else begin
            a_q     <= a_ext;
            b_q     <= b_ext;
            ctl_out <= ctl_in;
        end
    end

    always_comb begin
        a_wide = a_q;
        b_wide = b_q;
        mult   = a_wide * b_wide;
    end

    assign prod = mult;

endmodule

// File: rtl/mfm_out_stage.sv
module mfm_out_stage
    import mfm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hold_n,
    input  logic [2*W-1:0] prod,
    input  mfm_ctl_t       ctl,
    output logic [2*W-1:0] word_q,
    output logic           ovf_q
);
    localparam int PW = 2 * W;

    logic [PW-1:0] aligned;
    logic          lost_bit;

    always_comb begin
        aligned  = ctl.shift ? {prod[PW-2:0], 1'b0} : prod;
        lost_bit = ctl.any_signed ? (prod[PW-1] ^ prod[PW-2]) : prod[PW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            ovf_q  <= 1'b0;
        end else if (hold_n) begin
            word_q <= aligned;
            ovf_q  <= ctl.shift & lost_bit;
        end
    end

endmodule

// File: rtl/mixed_fxp_mul.sv
module mixed_fxp_mul
    import mfm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             a_signed,
    input  logic             b_signed,
    input  logic             a_abs,
    input  logic             b_abs,
    input  logic             shift_left,
    input  logic             hold_n,
    input  logic             hi_sel,
    input  logic             out_en,
    output logic [WIDTH-1:0] dout,
    output logic             dout_valid,
    output logic             ovf
);
    localparam int NOPS = 2;
    localparam int PW   = 2 * WIDTH;

    logic [NOPS-1:0][WIDTH-1:0] raw_ops;
    logic [NOPS-1:0]            fmt_signed, fmt_abs;
    logic signed [WIDTH:0]      ext_ops [NOPS];

    mfm_ctl_t       ctl_in, s1_ctl;
    logic [PW-1:0]  s1_prod;
    logic [PW-1:0]  out_word;
    logic           out_ovf;
    logic           s1_shift;

    assign raw_ops    = {b_in, a_in};
    assign fmt_signed = {b_signed, a_signed};
    assign fmt_abs    = {b_abs, a_abs};

    generate
        for (genvar g = 0; g < NOPS; g++) begin : g_opnd
            mfm_operand #(.W(WIDTH)) u_opnd (
                .raw       (raw_ops[g]),
                .is_signed (fmt_signed[g]),
                .take_abs  (fmt_abs[g]),
                .ext       (ext_ops[g])
            );
        end
    endgenerate

    always_comb begin
        ctl_in.shift      = shift_left;
        ctl_in.any_signed = a_signed | b_signed;
    end

    mfm_stage1 #(.W(WIDTH)) u_s1 (
        .clk     (clk),
        .rst     (rst),
        .a_ext   (ext_ops[0]),
        .b_ext   (ext_ops[1]),
        .ctl_in  (ctl_in),
        .prod    (s1_prod),
        .ctl_out (s1_ctl)
    );

    assign s1_shift = s1_ctl.shift;

    mfm_out_stage #(.W(WIDTH)) u_out (
        .clk    (clk),
        .rst    (rst),
        .hold_n (hold_n),
        .prod   (s1_prod),
        .ctl    (s1_ctl),
        .word_q (out_word),
        .ovf_q  (out_ovf)
    );

    always_comb begin
        if (!out_en)     dout = '0;
        else if (hi_sel) dout = out_word[PW-1:WIDTH];
        else             dout = out_word[WIDTH-1:0];
    end

    assign dout_valid = out_en;
    assign ovf        = out_ovf;

endmodule

// File: rtl/mfm_checker.sv
module mfm_checker #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           hold_n,
    input logic           out_en,
    input logic [W-1:0]   dout,
    input logic           dout_valid,
    input logic [2*W-1:0] out_word,
    input logic           out_ovf,
    input logic           s1_shift
);

    assert_port_gated_R7: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (dout == '0 && !dout_valid))
        else $error("R7 port not gated while disabled");

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (hold_n && !s1_shift) |=> !out_ovf)
        else $error("R9 overflow without shift");

    assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (rst)
        !hold_n |=> (out_word == $past(out_word) && out_ovf == $past(out_ovf)))
        else $error("R10 output register changed under hold");

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (out_word == '0 && !out_ovf))
        else $error("R11 output not cleared by reset");

endmodule

bind mixed_fxp_mul mfm_checker #(.W(WIDTH)) u_mfm_chk (
    .clk        (clk),
    .rst        (rst),
    .hold_n     (hold_n),
    .out_en     (out_en),
    .dout       (dout),
    .dout_valid (dout_valid),
    .out_word   (out_word),
    .out_ovf    (out_ovf),
    .s1_shift   (s1_shift)
);

// File: tb/mixed_fxp_mul_bench.sv
module mixed_fxp_mul_bench;
    localparam int TW = 4;
    localparam longint MOD = 64'sd1 << (2 * TW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [TW-1:0] a_in = '0, b_in = '0;
    logic a_signed = 0, b_signed = 0, a_abs = 0, b_abs = 0;
    logic shift_left = 0, hold_n = 1, hi_sel = 0, out_en = 1;
    logic [TW-1:0] dout;
    logic dout_valid, ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mixed_fxp_mul #(.WIDTH(TW)) u_mixed_fxp_mul (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .a_signed(a_signed), .b_signed(b_signed), .a_abs(a_abs), .b_abs(b_abs),
        .shift_left(shift_left), .hold_n(hold_n), .hi_sel(hi_sel), .out_en(out_en),
        .dout(dout), .dout_valid(dout_valid), .ovf(ovf)
    );

    function automatic longint opval(logic [TW-1:0] r, bit s, bit ab);
        longint v;
        if (!s) return longint'(r);
        v = r[TW-1] ? longint'(r) - (64'sd1 << TW) : longint'(r);
        if (ab && v < 0) v = -v;
        return v;
    endfunction

    function automatic longint exp_word(logic [TW-1:0] a, logic [TW-1:0] b,
                                        bit sa, bit sb, bit aa, bit ab, bit sh);
        longint p;
        p = opval(a, sa, aa) * opval(b, sb, ab);
        if (sh) p = p * 2;
        p = p % MOD;
        if (p < 0) p = p + MOD;
        return p;
    endfunction

    function automatic bit exp_ovf(logic [TW-1:0] a, logic [TW-1:0] b,
                                   bit sa, bit sb, bit aa, bit ab, bit sh);
        longint p;
        p = opval(a, sa, aa) * opval(b, sb, ab);
        if (!sh) return 0;
        if (sa || sb)
            return (p < -(64'sd1 << (2*TW-2))) || (p >= (64'sd1 << (2*TW-2)));
        return p >= (64'sd1 << (2*TW-1));
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reads both halves through the port (R6) at the current time.
    task automatic read_word(output longint w);
        logic [TW-1:0] lo, hi;
        hi_sel = 0; #1 lo = dout;
        hi_sel = 1; #1 hi = dout;
        hi_sel = 0;
        w = longint'({hi, lo});
    endtask

    task automatic drive(logic [TW-1:0] a, logic [TW-1:0] b,
                         bit sa, bit sb, bit aa, bit ab, bit sh);
        a_in = a; b_in = b; a_signed = sa; b_signed = sb;
        a_abs = aa; b_abs = ab; shift_left = sh;
    endtask

    string tag;
    longint w;

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        read_word(w);
        check("R11 reset word", w, 0);
        check("R11 reset ovf", ovf, 0);
        check("R7 valid with enable high", dout_valid, 1);
        rst = 0;

        // Sweep: R1 R2 R3 R4 R6 R8 R9
        for (int sh = 0; sh < 2; sh++)
            for (int f = 0; f < 16; f++)
                for (int a = 0; a < (1 << TW); a++)
                    for (int b = 0; b < (1 << TW); b++) begin
                        bit sa, sb, aa, ab;
                        sa = f[0]; sb = f[1]; aa = f[2]; ab = f[3];
                        @(negedge clk);
                        drive(TW'(a), TW'(b), sa, sb, aa, ab, sh[0]);
                        @(posedge clk); @(posedge clk); @(negedge clk);
                        if (sa && sb)       tag = "R2";
                        else if (sa || sb)  tag = "R3";
                        else                tag = "R1";
                        if ((sa && aa) || (sb && ab) || (!sa && aa) || (!sb && ab))
                            tag = {tag, "/R4"};
                        if (sh != 0) tag = {tag, "/R8"};
                        tag = {tag, "/R6"};
                        read_word(w);
                        check(tag, w, exp_word(TW'(a), TW'(b), sa, sb, aa, ab, sh[0]));
                        check("R9 ovf", ovf, exp_ovf(TW'(a), TW'(b), sa, sb, aa, ab, sh[0]));
                    end

        // R5: back-to-back issue, one result per cycle, two-cycle latency
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                read_word(w);
                check("R5 pipelined", w, exp_word(TW'(i + 1), TW'(2*i + 3), 1, 0, 0, 0, 0));
            end
            drive(TW'(i + 3), TW'(2*i + 7), 1, 0, 0, 0, 0);
        end

        // R10: hold freezes output, release picks up stage one
        @(negedge clk);
        drive(4'd5, 4'd3, 0, 0, 0, 0, 1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        hold_n = 0;
        drive(4'd7, 4'd6, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        read_word(w);
        check("R10 held word", w, 30);
        check("R10 held ovf", ovf, 0);
        hold_n = 1;
        @(posedge clk); @(negedge clk);
        read_word(w);
        check("R10 released word", w, 42);

        // R7: disabled port
        out_en = 0;
        hi_sel = 0; #1 check("R7 low half gated", dout, 0);
        hi_sel = 1; #1 check("R7 high half gated", dout, 0);
        check("R7 valid low", dout_valid, 0);
        hi_sel = 0; out_en = 1;

        // R11: reset after activity
        @(negedge clk);
        drive(4'd8, 4'd8, 1, 1, 0, 0, 1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 signed overflow", ovf, 1);
        rst = 1;
        @(posedge clk); @(negedge clk);
        read_word(w);
        check("R11 reset after use", w, 0);
        check("R11 ovf after reset", ovf, 0);
        rst = 0;

        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule